// File: doc/BRIEF.md
# LCD Supply Source Sequencer

The block selects the supply that feeds a display panel: none, an external source, or an internal charge-pump source. Software writes a 2-bit mode value in the bus clock domain. The value crosses into the slow-clock domain through a two-flop synchronizer. A slow-clock state machine then runs a fixed ordering of source enables and an active-low panel reset. The ordering depends on the mode change that was requested.

Power-up turns on a source first and releases the panel reset after a fixed delay. Two power-down paths are available. The immediate path asserts the reset and drops the source one slow cycle later. The frame-aligned path first waits for an end-of-frame pulse from the display controller, then follows the same steps. A status flag tells software when the panel is powered and out of reset. A switch directly between the two supply sources is rejected, and so is any write that arrives while a sequence is still running.

Top module: `lcd_supply_seq`

## Requirements
- R1: After reset both source enables are 0, the panel reset output is 0 (asserted), the status flag is 0 and the held mode is 0.
- R2: Mode encoding: 0 and 1 select no supply, 2 selects the external source, 3 selects the internal charge pump. The first output change caused by a write appears on the third rising slow-clock edge after the write completes.
- R3: Changing from mode 0 or 1 to mode 2 raises the external enable first. The panel reset is released one slow cycle later, and the status flag goes to 1 on the same edge.
- R4: Changing from mode 0 or 1 to mode 3 raises the internal enable first. The panel reset is released 15 slow cycles later, and the status flag goes to 1 on the same edge.
- R5: Changing from mode 2 or 3 to mode 0 asserts the panel reset first. One slow cycle later the active enable falls and the status flag goes to 0.
- R6: Changing from mode 2 or 3 to mode 1 holds all outputs until an end-of-frame pulse is sampled. The panel reset is asserted on that edge. One slow cycle later the enable falls and the status flag goes to 0.
- R7: Writing 3 while in mode 2, or 2 while in mode 3, leaves all outputs unchanged.
- R8: A write that arrives while a sequence is running is discarded and is not acted on later. A write equal to the held mode changes nothing.
- R9: The two enables are never high together. The panel reset is only released while an enable has been high for at least one cycle. An enable only falls after the reset has been asserted for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus clock for the mode write |
| slowClk | input | 1 | Slow clock for sequencing |
| rstN | input | 1 | Asynchronous active-low reset, both domains |
| modeWe | input | 1 | Mode write strobe (bus domain) |
| modeWdata | input | 2 | Mode value to write |
| frameEnd | input | 1 | End-of-frame pulse, slow domain |
| extSupplyEn | output | 1 | External supply source enable |
| intSupplyEn | output | 1 | Internal charge-pump enable |
| panelRstN | output | 1 | Active-low panel reset |
| supplyReady | output | 1 | Status: supply on and panel out of reset |

## Verification
The bench uses the default delays: one cycle for the external power-up, fifteen cycles for the internal power-up, one cycle for power-down, and two synchronizer stages. With these values, every edge of every sequence can be sampled by exact slow-cycle counts. The fifteen-cycle window is long enough that a second write lands while a sequence is still running. The slow clock runs at one eighth of the bus clock, so a write completes well inside one slow period. This makes the third-edge latency deterministic.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  typedef enum logic [1:0] {
    MODE_OFF_A = 2'd0,
    MODE_OFF_B = 2'd1,
    MODE_EXT   = 2'd2,
    MODE_INT   = 2'd3
  } lcd_mode_t;

  typedef enum logic [1:0] {
    CNT_EXT_UP = 2'd0,
    CNT_INT_UP = 2'd1,
    CNT_DOWN   = 2'd2
  } cnt_sel_t;

  typedef struct packed {
    logic     loadMode;
    logic     setExt;
    logic     setInt;
    logic     releaseRst;
    logic     assertRst;
    logic     dropEn;
    logic     setStatus;
    logic     clrStatus;
    logic     loadCnt;
    cnt_sel_t cntSel;
    logic     countDown;
  } seq_strobe_t;
endpackage

// File: rtl/lcd_mode_sync.sv
module lcd_mode_sync #(
  parameter int MODE_W = 2,
  parameter int STAGES = 2
) (
  input  logic              busClk,
  input  logic              slowClk,
  input  logic              rstN,
  input  logic              modeWe,
  input  logic [MODE_W-1:0] modeWdata,
  output logic [MODE_W-1:0] syncMode,
  output logic              modeChanged
);
  logic [MODE_W-1:0] modeReg;
  logic [MODE_W-1:0] stage [STAGES];
  logic [MODE_W-1:0] prevMode;

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN)       modeReg <= '0;
    else if (modeWe) modeReg <= modeWdata;
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge slowClk or negedge rstN) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= modeReg;
      end
    end else begin : g_next
      always_ff @(posedge slowClk or negedge rstN) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= stage[s-1];
      end
    end
  end

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) prevMode <= '0;
    else       prevMode <= stage[STAGES-1];
  end

  assign syncMode    = stage[STAGES-1];
  assign modeChanged = (stage[STAGES-1] != prevMode);
endmodule

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_seq_pkg::*;
(
  input  logic        slowClk,
  input  logic        rstN,
  input  logic        modeChanged,
  input  logic [1:0]  reqMode,
  input  logic [1:0]  curMode,
  input  logic        cntDone,
  input  logic        frameEnd,
  output seq_strobe_t stb
);
  typedef enum logic [1:0] {S_IDLE, S_UP, S_EOF, S_DOWN} state_t;
  state_t state, nextState;

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb       = '0;
    nextState = state;
    unique case (state)
      S_IDLE: begin
        if (modeChanged && reqMode != curMode) begin
          if (!curMode[1]) begin
            stb.loadMode = 1'b1;
            if (reqMode[1]) begin
              stb.loadCnt = 1'b1;
              if (reqMode == MODE_EXT) begin
                stb.setExt = 1'b1;
                stb.cntSel = CNT_EXT_UP;
              end else begin
                stb.setInt = 1'b1;
                stb.cntSel = CNT_INT_UP;
              end
              nextState = S_UP;
            end
          end else if (!reqMode[1]) begin
            stb.loadMode = 1'b1;
            if (reqMode == MODE_OFF_A) begin
              stb.assertRst = 1'b1;
              stb.loadCnt   = 1'b1;
              stb.cntSel    = CNT_DOWN;
              nextState     = S_DOWN;
            end else begin
              nextState = S_EOF;
            end
          end
        end
      end
      S_UP: begin
        if (cntDone) begin
          stb.releaseRst = 1'b1;
          stb.setStatus  = 1'b1;
          nextState      = S_IDLE;
        end else begin
          stb.countDown = 1'b1;
        end
      end
      S_EOF: begin
        if (frameEnd) begin
          stb.assertRst = 1'b1;
          stb.loadCnt   = 1'b1;
          stb.cntSel    = CNT_DOWN;
          nextState     = S_DOWN;
        end
      end
      S_DOWN: begin
        if (cntDone) begin
          stb.dropEn    = 1'b1;
          stb.clrStatus = 1'b1;
          nextState     = S_IDLE;
        end else begin
          stb.countDown = 1'b1;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end
endmodule

// File: rtl/lcd_seq_dp.sv
module lcd_seq_dp
  import lcd_seq_pkg::*;
#(
  parameter int EXT_UP_CYCLES = 1,
  parameter int INT_UP_CYCLES = 15,
  parameter int DOWN_CYCLES   = 1
) (
  input  logic        slowClk,
  input  logic        rstN,
  input  seq_strobe_t stb,
  input  logic [1:0]  reqMode,
  output logic [1:0]  curMode,
  output logic        cntDone,
  output logic        extEn,
  output logic        intEn,
  output logic        panelRst,
  output logic        status
);
  localparam int MAX_UP  = (EXT_UP_CYCLES > INT_UP_CYCLES) ? EXT_UP_CYCLES : INT_UP_CYCLES;
  localparam int MAX_DLY = (MAX_UP > DOWN_CYCLES) ? MAX_UP : DOWN_CYCLES;
  localparam int CNT_W   = $clog2(MAX_DLY + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;

  always_comb begin
    unique case (stb.cntSel)
      CNT_EXT_UP: loadVal = CNT_W'(EXT_UP_CYCLES);
      CNT_INT_UP: loadVal = CNT_W'(INT_UP_CYCLES);
      default:    loadVal = CNT_W'(DOWN_CYCLES);
    endcase
  end

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      curMode  <= MODE_OFF_A;
      extEn    <= 1'b0;
      intEn    <= 1'b0;
      panelRst <= 1'b0;
      status   <= 1'b0;
    end else begin
      if (stb.loadCnt)        cnt <= loadVal;
      else if (stb.countDown) cnt <= cnt - 1'b1;
      if (stb.loadMode) curMode <= reqMode;
      if (stb.setExt)      extEn <= 1'b1;
      else if (stb.dropEn) extEn <= 1'b0;
      if (stb.setInt)      intEn <= 1'b1;
      else if (stb.dropEn) intEn <= 1'b0;
      if (stb.releaseRst)     panelRst <= 1'b1;
      else if (stb.assertRst) panelRst <= 1'b0;
      if (stb.setStatus)      status <= 1'b1;
      else if (stb.clrStatus) status <= 1'b0;
    end
  end

  assign cntDone = (cnt == CNT_W'(1));
endmodule

// File: rtl/lcd_supply_seq.sv
module lcd_supply_seq
  import lcd_seq_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int EXT_UP_CYCLES = 1,
  parameter int INT_UP_CYCLES = 15,
  parameter int DOWN_CYCLES   = 1
) (
  input  logic       busClk,
  input  logic       slowClk,
  input  logic       rstN,
  input  logic       modeWe,
  input  logic [1:0] modeWdata,
  input  logic       frameEnd,
  output logic       extSupplyEn,
  output logic       intSupplyEn,
  output logic       panelRstN,
  output logic       supplyReady
);
  logic [1:0]  syncMode;
  logic [1:0]  curMode;
  logic        modeChanged;
  logic        cntDone;
  seq_strobe_t stb;

  lcd_mode_sync #(.MODE_W(2), .STAGES(SYNC_STAGES)) u_sync (
    .busClk(busClk), .slowClk(slowClk), .rstN(rstN),
    .modeWe(modeWe), .modeWdata(modeWdata),
    .syncMode(syncMode), .modeChanged(modeChanged)
  );

  lcd_seq_ctrl u_ctrl (
    .slowClk(slowClk), .rstN(rstN), .modeChanged(modeChanged),
    .reqMode(syncMode), .curMode(curMode), .cntDone(cntDone),
    .frameEnd(frameEnd), .stb(stb)
  );

  lcd_seq_dp #(
    .EXT_UP_CYCLES(EXT_UP_CYCLES), .INT_UP_CYCLES(INT_UP_CYCLES),
    .DOWN_CYCLES(DOWN_CYCLES)
  ) u_dp (
    .slowClk(slowClk), .rstN(rstN), .stb(stb), .reqMode(syncMode),
    .curMode(curMode), .cntDone(cntDone), .extEn(extSupplyEn),
    .intEn(intSupplyEn), .panelRst(panelRstN), .status(supplyReady)
  );
endmodule

// File: rtl/lcd_supply_seq_chk.sv
module lcd_supply_seq_chk (
  input logic slowClk,
  input logic rstN,
  input logic extSupplyEn,
  input logic intSupplyEn,
  input logic panelRstN,
  input logic supplyReady
);
  // R9: sources are mutually exclusive
  p_src_exclusive_r9: assert property (@(posedge slowClk) disable iff (!rstN)
    !(extSupplyEn && intSupplyEn));

  // R9, R3, R4: reset release only after an enable was already high
  p_release_after_en_r9: assert property (@(posedge slowClk) disable iff (!rstN)
    $rose(panelRstN) |-> $past(extSupplyEn || intSupplyEn));

  // R9, R5, R6: external enable falls only after reset held asserted
  p_ext_drop_order_r5: assert property (@(posedge slowClk) disable iff (!rstN)
    $fell(extSupplyEn) |-> (!panelRstN && $past(!panelRstN)));

  // R9, R5, R6: internal enable falls only after reset held asserted
  p_int_drop_order_r6: assert property (@(posedge slowClk) disable iff (!rstN)
    $fell(intSupplyEn) |-> (!panelRstN && $past(!panelRstN)));

  // R4: charge pump turns on while the panel is still in reset
  p_int_on_in_reset_r4: assert property (@(posedge slowClk) disable iff (!rstN)
    $rose(intSupplyEn) |-> !panelRstN);

  // R3, R4: a released panel always reports ready
  p_ready_when_released_r3: assert property (@(posedge slowClk) disable iff (!rstN)
    panelRstN |-> supplyReady);

  // R5: status clears together with the supply being removed
  p_ready_clear_r5: assert property (@(posedge slowClk) disable iff (!rstN)
    $fell(supplyReady) |-> !(extSupplyEn || intSupplyEn));
endmodule

bind lcd_supply_seq lcd_supply_seq_chk u_chk (
  .slowClk(slowClk), .rstN(rstN), .extSupplyEn(extSupplyEn),
  .intSupplyEn(intSupplyEn), .panelRstN(panelRstN), .supplyReady(supplyReady)
);

// File: tb/lcd_supply_seq_test.sv
module lcd_supply_seq_test;
  logic busClk = 1'b0;
  logic slowClk = 1'b0;
  logic rstN = 1'b0;
  logic modeWe = 1'b0;
  logic [1:0] modeWdata = 2'd0;
  logic frameEnd = 1'b0;
  logic extSupplyEn, intSupplyEn, panelRstN, supplyReady;
  logic frameGen = 1'b0;
  int   testsRun = 0;
  int   testsFailed = 0;
  logic finished = 1'b0;

  always #5 busClk = ~busClk;
  always #40 slowClk = ~slowClk;

  lcd_supply_seq uut (
    .busClk(busClk), .slowClk(slowClk), .rstN(rstN), .modeWe(modeWe),
    .modeWdata(modeWdata), .frameEnd(frameEnd), .extSupplyEn(extSupplyEn),
    .intSupplyEn(intSupplyEn), .panelRstN(panelRstN), .supplyReady(supplyReady)
  );

  // vector: {mode[1:0], ext, int, rstN, ready}
  localparam logic [5:0] VEC [9] = '{
    {2'd2, 4'b1011},
    {2'd3, 4'b1011},
    {2'd0, 4'b0000},
    {2'd3, 4'b0111},
    {2'd2, 4'b0111},
    {2'd1, 4'b0000},
    {2'd2, 4'b1011},
    {2'd1, 4'b0000},
    {2'd0, 4'b0000}
  };

  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {extSupplyEn, intSupplyEn, panelRstN, supplyReady};
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: ext/int/rstN/ready actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic writeMode(input logic [1:0] m);
    @(posedge slowClk);
    #5;
    @(negedge busClk);
    modeWe = 1'b1;
    modeWdata = m;
    @(negedge busClk);
    modeWe = 1'b0;
  endtask

  task automatic slowEdges(input int n);
    repeat (n) @(posedge slowClk);
    #2;
  endtask

  initial begin
    int phase;
    phase = 0;
    forever begin
      @(negedge slowClk);
      phase = (phase + 1) % 8;
      frameEnd = frameGen && (phase == 0);
    end
  end

  task automatic finish_run();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    #3000000;
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    #200;
    check("R1 reset state", 4'b0000);
    rstN = 1'b1;
    slowEdges(3);
    check("R1 idle after reset", 4'b0000);

    // table walk, frame pulses running
    frameGen = 1'b1;
    for (int i = 0; i < 9; i++) begin
      writeMode(VEC[i][5:4]);
      slowEdges(30);
      check($sformatf("R7/R6/R3/R4/R5 vector %0d", i), VEC[i][3:0]);
    end
    frameGen = 1'b0;

    // R2/R3: external power-up edge timing
    writeMode(2'd2);
    slowEdges(2);
    check("R2 no change before third edge", 4'b0000);
    slowEdges(1);
    check("R3 ext enable first", 4'b1000);
    slowEdges(1);
    check("R3 reset released one cycle later", 4'b1011);

    // R5: immediate power-down
    writeMode(2'd0);
    slowEdges(3);
    check("R5 reset asserted first", 4'b1001);
    slowEdges(1);
    check("R5 enable dropped one cycle later", 4'b0000);

    // R4: internal power-up
    writeMode(2'd3);
    slowEdges(3);
    check("R4 internal enable first", 4'b0100);
    slowEdges(14);
    check("R4 still in reset at cycle 14", 4'b0100);
    slowEdges(1);
    check("R4 reset released at cycle 15", 4'b0111);

    // R6: frame-aligned power-down
    writeMode(2'd1);
    slowEdges(12);
    check("R6 waiting for end of frame", 4'b0111);
    @(negedge slowClk);
    frameEnd = 1'b1;
    @(negedge slowClk);
    frameEnd = 1'b0;
    #2;
    check("R6 reset asserted on frame end", 4'b0101);
    slowEdges(1);
    check("R6 enable dropped after frame end", 4'b0000);

    // R8: write during a running sequence is discarded
    writeMode(2'd3);
    slowEdges(5);
    writeMode(2'd0);
    slowEdges(40);
    check("R8 mid-sequence write discarded", 4'b0111);
    // R8: write equal to held mode
    writeMode(2'd3);
    slowEdges(10);
    check("R8 equal write no effect", 4'b0111);
    writeMode(2'd0);
    slowEdges(10);
    check("R8 later write still accepted", 4'b0000);

    finish_run();
  end
endmodule